// File: doc/BRIEF.md
# Chip-Select Enable Gating

This block stops a set of memory and peripheral chip selects from reaching their devices until software has written the configuration those selects depend on. It keeps one sticky "written" flag for each configuration register. From these flags it forms one enable per chip-select group: upper memory, lower memory, mid-range memory and peripheral. It then ANDs each enable with the raw address-decode hits of its group, so a group that has not been programmed can never drive a select low.

The upper-memory group is live straight out of reset, so a boot region can be fetched. The lower-memory group needs only its own register. The mid-range group needs its base register and the shared size register. The peripheral group needs its base register and the same shared size register. Where two registers are needed, they may be written in either order. Only writes count: a read strobe on the same interface leaves every flag as it was.

The block also contains the address comparators that produce the raw hits. Each comparator is a plain base/limit or base/size comparison against the programmed values. The block takes the address bits above the peripheral granularity and drives active-low selects from them combinationally.

Top module: `csel_gate_top`

## Requirements
- R1: Out of reset, with no write made, the upper group enable is 1. `ucs_n` is low for any address in the last 1 KiB block, which is the reset upper limit 10'h3FF.
- R2: A read strobe (`cfg_rd` high, `cfg_wr` low) changes no enable, no select output and no stored value, whatever the select code.
- R3: After a write with select code 1 (lower), the lower enable `grp_en[1]` is 1 from the following clock.
- R4: The mid-range enable `grp_en[2]` becomes 1 only after both code 2 (mid-range base) and code 4 (shared size) have been written, in either order.
- R5: The peripheral enable `grp_en[3]` becomes 1 only after both code 3 (peripheral base) and code 4 (shared size) have been written, in either order.
- R6: Every written flag stays set until reset. Later writes to any code never clear an enable.
- R7: Synchronous active-low reset returns `grp_en` to 4'b0001, with bit 0 upper, bit 1 lower, bit 2 mid-range and bit 3 peripheral.
- R8: All selects are active low. A select is low only when its raw hit is true and its group enable is 1.
- R9: Upper hit: the address bits [19:10] are greater than or equal to the upper limit (write data [9:0] of code 0).
- R10: Lower hit: the address bits [19:10] are less than or equal to the lower limit (write data [9:0] of code 1).
- R11: Mid-range select i (i = 0..3) hits when blk = addr[19:10] is at least the base (data [9:0] of code 2) and (blk - base) >> sz equals i. Here sz is data [2:0] of code 4, and the selects are one-hot or idle.
- R12: Peripheral select i (i = 0..3) hits when addr[19:7] equals the peripheral base (data [12:0] of code 3) plus i, modulo 2^13.
- R13: Writes with select codes 5, 6 and 7 change no enable and no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe (never activates) |
| cfg_sel | input | 3 | Register select code 0..4 |
| cfg_wdata | input | 13 | Write data |
| bus_addr | input | 13 | Address bits [19:7] |
| grp_en | output | 4 | Group enables {periph, mid, lower, upper} |
| ucs_n | output | 1 | Upper-memory select, active low |
| lcs_n | output | 1 | Lower-memory select, active low |
| mcs_n | output | 4 | Mid-range selects, active low |
| pcs_n | output | 4 | Peripheral selects, active low |

## Verification
A flag that is lost or set when it should not be shows on `grp_en` at the first negative edge after the offending clock. It also shows on the selects as soon as the bench presents an address inside that group's decoded window. Checks are therefore made after every single operation, with addresses drawn both at random and around the programmed bases. A stored base or size that is wrong shows only through the decode, so each write is followed by address probes at the window boundaries. Writes in both orders and mid-run resets show any dependence on write order or any flag that fails to clear.

// File: rtl/csel_pkg.sv
// Package: register select codes and group bit positions shared by the
// chip-select enable gating block and its bench.
package csel_pkg;
    typedef enum logic [2:0] {
        SEL_UPPER = 3'd0,
        SEL_LOWER = 3'd1,
        SEL_MBASE = 3'd2,
        SEL_PBASE = 3'd3,
        SEL_SIZE  = 3'd4
    } cfg_sel_e;

    localparam int GRP_UP  = 0;
    localparam int GRP_LO  = 1;
    localparam int GRP_MID = 2;
    localparam int GRP_PER = 3;
    localparam int NUM_GRP = 4;
endpackage

// File: rtl/csel_regfile.sv
// Configuration store and activation tracking.
// Holds the programmed limits/bases/size and one sticky written flag per
// register code 1..4; forms the four group enables from those flags.
// Assumes synchronous active-low reset and that cfg_sel codes 5..7 are unused.
module csel_regfile
    import csel_pkg::*;
#(
    parameter int RW   = 10,
    parameter int PW   = 13,
    parameter int SZ_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_rd,
    input  logic [2:0]      cfg_sel,
    input  logic [PW-1:0]   cfg_wdata,
    output logic [RW-1:0]   up_lim,
    output logic [RW-1:0]   lo_lim,
    output logic [RW-1:0]   mid_base,
    output logic [SZ_W-1:0] mid_sz,
    output logic [PW-1:0]   per_base,
    output logic [NUM_GRP-1:0] grp_en
);
    localparam int FIRST_CODE = 1;
    localparam int LAST_CODE  = 4;

    logic [LAST_CODE:FIRST_CODE] seen;
    logic                        en_up;

    // Store configuration values on writes to their codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_lim   <= '1;
            lo_lim   <= '0;
            mid_base <= '0;
            mid_sz   <= '0;
            per_base <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_UPPER: up_lim   <= cfg_wdata[RW-1:0];
                SEL_LOWER: lo_lim   <= cfg_wdata[RW-1:0];
                SEL_MBASE: mid_base <= cfg_wdata[RW-1:0];
                SEL_PBASE: per_base <= cfg_wdata;
                SEL_SIZE:  mid_sz   <= cfg_wdata[SZ_W-1:0];
                default:   ;
            endcase
        end
    end

    // One sticky written flag per tracked register code.
    for (genvar g = FIRST_CODE; g <= LAST_CODE; g++) begin : g_seen
        always_ff @(posedge clk) begin
            if (!rst_n)
                seen[g] <= 1'b0;
            else if (cfg_wr && cfg_sel == 3'(g))
                seen[g] <= 1'b1;
        end
    end

    // Upper group is live from reset and never withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_up <= 1'b1;
    end

    // Combine flags into group enables.
    always_comb begin
        grp_en          = '0;
        grp_en[GRP_UP]  = en_up;
        grp_en[GRP_LO]  = seen[SEL_LOWER];
        grp_en[GRP_MID] = seen[SEL_MBASE] & seen[SEL_SIZE];
        grp_en[GRP_PER] = seen[SEL_PBASE] & seen[SEL_SIZE];
    end

    // R7: enables come out of reset as upper-only.
    a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> grp_en == 4'b0001);
    // R2: a pure read leaves every flag untouched.
    a_r2_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !cfg_wr) |=> $stable(seen));
    // R6: flags never fall outside reset.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((seen & $past(seen)) == $past(seen)));
    // R3: a lower write enables the lower group next cycle.
    a_r3_lower_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_LOWER) |=> grp_en[GRP_LO]);
    // R1: upper group stays enabled.
    a_r1_upper_live: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en[GRP_UP]);
endmodule

// File: rtl/csel_decode.sv
// Raw address decode for all chip-select groups.
// Compares the address (bits above peripheral granularity) against the
// programmed limits, mid-range base/size and peripheral base. Purely
// combinational; assumes NUM_MCS and NUM_PCS fit the base field widths.
module csel_decode #(
    parameter int ADDR_W  = 20,
    parameter int BLK_SH  = 10,
    parameter int PCS_SH  = 7,
    parameter int SZ_W    = 3,
    parameter int NUM_MCS = 4,
    parameter int NUM_PCS = 4
) (
    input  logic [ADDR_W-1:PCS_SH]        bus_addr,
    input  logic [ADDR_W-BLK_SH-1:0]      up_lim,
    input  logic [ADDR_W-BLK_SH-1:0]      lo_lim,
    input  logic [ADDR_W-BLK_SH-1:0]      mid_base,
    input  logic [SZ_W-1:0]               mid_sz,
    input  logic [ADDR_W-PCS_SH-1:0]      per_base,
    output logic                          raw_ucs,
    output logic                          raw_lcs,
    output logic [NUM_MCS-1:0]            raw_mcs,
    output logic [NUM_PCS-1:0]            raw_pcs
);
    localparam int RW = ADDR_W - BLK_SH;
    localparam int PW = ADDR_W - PCS_SH;

    logic [RW-1:0] blk;
    logic [RW-1:0] mid_off;
    logic [RW-1:0] mid_idx;
    logic          mid_ge;
    logic [PW-1:0] pblk;

    // Block-granular views of the address and mid-range offset.
    always_comb begin
        blk     = bus_addr[ADDR_W-1:BLK_SH];
        pblk    = bus_addr;
        mid_ge  = blk >= mid_base;
        mid_off = blk - mid_base;
        mid_idx = mid_off >> mid_sz;
        raw_ucs = blk >= up_lim;
        raw_lcs = blk <= lo_lim;
    end

    // One comparator per mid-range select.
    for (genvar i = 0; i < NUM_MCS; i++) begin : g_mcs
        always_comb raw_mcs[i] = mid_ge && (mid_idx == RW'(i));
    end

    // One comparator per peripheral select.
    for (genvar i = 0; i < NUM_PCS; i++) begin : g_pcs
        always_comb raw_pcs[i] = (pblk == PW'(per_base + PW'(i)));
    end
endmodule

// File: rtl/csel_gate_top.sv
// Chip-select enable gating top.
// Tracks configuration writes, decodes the address, and lets each group's
// selects assert (low) only once the group is enabled. Assumes address is
// stable while being decoded; outputs are combinational from state and addr.
module csel_gate_top
    import csel_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BLK_SH  = 10,
    parameter int PCS_SH  = 7,
    parameter int SZ_W    = 3,
    parameter int NUM_MCS = 4,
    parameter int NUM_PCS = 4,
    localparam int RW     = ADDR_W - BLK_SH,
    localparam int PW     = ADDR_W - PCS_SH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    cfg_rd,
    input  logic [2:0]              cfg_sel,
    input  logic [PW-1:0]           cfg_wdata,
    input  logic [ADDR_W-1:PCS_SH]  bus_addr,
    output logic [NUM_GRP-1:0]      grp_en,
    output logic                    ucs_n,
    output logic                    lcs_n,
    output logic [NUM_MCS-1:0]      mcs_n,
    output logic [NUM_PCS-1:0]      pcs_n
);
    logic [RW-1:0]      up_lim, lo_lim, mid_base;
    logic [SZ_W-1:0]    mid_sz;
    logic [PW-1:0]      per_base;
    logic               raw_ucs, raw_lcs;
    logic [NUM_MCS-1:0] raw_mcs;
    logic [NUM_PCS-1:0] raw_pcs;

    csel_regfile #(.RW(RW), .PW(PW), .SZ_W(SZ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .up_lim(up_lim), .lo_lim(lo_lim), .mid_base(mid_base),
        .mid_sz(mid_sz), .per_base(per_base), .grp_en(grp_en)
    );

    csel_decode #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .PCS_SH(PCS_SH),
                  .SZ_W(SZ_W), .NUM_MCS(NUM_MCS), .NUM_PCS(NUM_PCS)) u_dec (
        .bus_addr(bus_addr), .up_lim(up_lim), .lo_lim(lo_lim),
        .mid_base(mid_base), .mid_sz(mid_sz), .per_base(per_base),
        .raw_ucs(raw_ucs), .raw_lcs(raw_lcs),
        .raw_mcs(raw_mcs), .raw_pcs(raw_pcs)
    );

    // Gate raw hits with group enables and drive active-low selects.
    always_comb begin
        ucs_n = ~(raw_ucs & grp_en[GRP_UP]);
        lcs_n = ~(raw_lcs & grp_en[GRP_LO]);
        mcs_n = ~(raw_mcs & {NUM_MCS{grp_en[GRP_MID]}});
        pcs_n = ~(raw_pcs & {NUM_PCS{grp_en[GRP_PER]}});
    end

    // R8: no select of a disabled group is ever low.
    a_r8_lcs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !lcs_n |-> grp_en[GRP_LO]);
    a_r8_mcs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mcs_n != '1) |-> grp_en[GRP_MID]);
    a_r8_pcs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pcs_n != '1) |-> grp_en[GRP_PER]);
    // R11: at most one mid-range select at a time.
    a_r11_mcs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mcs_n));
    // R12: at most one peripheral select at a time.
    a_r12_pcs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n));
endmodule

// File: tb/csel_gate_top_tb.sv
// Self-checking bench: directed corner cases plus seeded random operations,
// compared against a behavioural model kept in bench variables.
module csel_gate_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [12:0] cfg_wdata = '0;
    logic [19:7] bus_addr = '0;
    logic [3:0]  grp_en;
    logic        ucs_n, lcs_n;
    logic [3:0]  mcs_n, pcs_n;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [9:0]  m_up, m_lo, m_mb;
    logic [2:0]  m_sz;
    logic [12:0] m_pb;
    logic [4:1]  m_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_gate_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
        .grp_en(grp_en), .ucs_n(ucs_n), .lcs_n(lcs_n),
        .mcs_n(mcs_n), .pcs_n(pcs_n)
    );

    function automatic logic [3:0] exp_en();
        return {m_seen[3] & m_seen[4], m_seen[2] & m_seen[4], m_seen[1], 1'b1};
    endfunction

    function automatic logic [3:0] exp_mcs_n(logic [19:7] a);
        logic [9:0] blk = a[19:10];
        logic [9:0] q;
        logic [3:0] hit = '0;
        if (blk >= m_mb) begin
            q = (blk - m_mb) >> m_sz;
            if (q < 10'd4) hit[q[1:0]] = 1'b1;
        end
        return ~(hit & {4{exp_en()[2]}});
    endfunction

    function automatic logic [3:0] exp_pcs_n(logic [19:7] a);
        logic [3:0] hit = '0;
        for (int i = 0; i < 4; i++)
            hit[i] = (a == 13'(m_pb + 13'(i)));
        return ~(hit & {4{exp_en()[3]}});
    endfunction

    task automatic cmp(string tag, string what, logic [3:0] act, logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Present an address and compare every output with the model.
    task automatic probe(string tag, logic [19:7] a);
        bus_addr = a;
        #1;
        cmp(tag, "grp_en", grp_en, exp_en());
        cmp(tag, "ucs_n", {3'b0, ucs_n}, {3'b0, ~(a[19:10] >= m_up)});
        cmp(tag, "lcs_n", {3'b0, lcs_n}, {3'b0, ~((a[19:10] <= m_lo) & exp_en()[1])});
        cmp(tag, "mcs_n", mcs_n, exp_mcs_n(a));
        cmp(tag, "pcs_n", pcs_n, exp_pcs_n(a));
    endtask

    task automatic model_reset();
        m_up = '1; m_lo = '0; m_mb = '0; m_sz = '0; m_pb = '0; m_seen = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_write(logic [2:0] sel, logic [12:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
        case (sel)
            3'd0: m_up = d[9:0];
            3'd1: begin m_lo = d[9:0]; m_seen[1] = 1'b1; end
            3'd2: begin m_mb = d[9:0]; m_seen[2] = 1'b1; end
            3'd3: begin m_pb = d;      m_seen[3] = 1'b1; end
            3'd4: begin m_sz = d[2:0]; m_seen[4] = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic do_read(logic [2:0] sel);
        @(negedge clk); cfg_rd = 1'b1; cfg_sel = sel;
        @(negedge clk); cfg_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        do_reset();
        // R7 / R1 / R9: reset state, upper block live
        cmp("R7", "grp_en reset", grp_en, 4'b0001);
        probe("R1", 13'h1FF8);
        probe("R9", 13'h1FF7);
        probe("R8", 13'h0000);
        // R2: reads on every code change nothing
        for (int s = 0; s < 8; s++) do_read(3'(s));
        probe("R2", 13'h0000);
        // R13: unused codes
        do_write(3'd5, 13'h1FFF); do_write(3'd6, 13'h1FFF); do_write(3'd7, 13'h1FFF);
        probe("R13", 13'h0000);
        probe("R13", 13'h0040);
        // R3 / R10: lower limit 5
        do_write(3'd1, 13'd5);
        probe("R3", {10'd5, 3'd7});
        probe("R10", {10'd6, 3'd0});
        // R4 / R5: size alone enables nothing
        do_write(3'd4, 13'd1);
        probe("R4", {10'd0, 3'd0});
        probe("R5", 13'd0);
        do_write(3'd2, 13'd8);
        probe("R11", {10'd8, 3'd0});
        probe("R11", {10'd10, 3'd0});
        probe("R11", {10'd15, 3'd7});
        probe("R11", {10'd16, 3'd0});
        probe("R11", {10'd7, 3'd7});
        do_write(3'd3, 13'd100);
        probe("R12", 13'd100);
        probe("R12", 13'd103);
        probe("R12", 13'd104);
        probe("R12", 13'd99);
        // R6: rewrites keep all enables
        do_write(3'd1, 13'd0); do_write(3'd4, 13'd0);
        probe("R6", 13'd100);
        probe("R6", {10'd8, 3'd0});
        // R7 then reversed order for R4
        do_reset();
        cmp("R7", "grp_en re-reset", grp_en, 4'b0001);
        do_write(3'd2, 13'd3);
        probe("R4", {10'd3, 3'd0});
        do_write(3'd4, 13'd2);
        probe("R4", {10'd3, 3'd0});
        // peripheral wrap at top of range
        do_write(3'd3, 13'h1FFE);
        probe("R12", 13'h1FFF);
        probe("R12", 13'h0001);
        // random mix
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 9);
            if (op < 4) do_write(3'($urandom_range(0, 7)), 13'($urandom));
            else if (op < 5) do_read(3'($urandom_range(0, 7)));
            else if (op == 5 && $urandom_range(0, 9) == 0) do_reset();
            if ($urandom_range(0, 1) == 0)
                probe("R8", 13'($urandom));
            else if ($urandom_range(0, 1) == 0)
                probe("R11", {10'(m_mb + 10'($urandom_range(0, 40))), 3'($urandom)});
            else
                probe("R12", 13'(m_pb + 13'($urandom_range(0, 5))));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule